// File: doc/BRIEF.md
# Smart Card T=0 Character Transceiver

This block moves asynchronous characters between a host and a smart card over one shared, open-drain I/O line. The block only pulls the line low or lets it go, and it reads the line back at all times. The host writes bytes into a two-entry transmit buffer and reads bytes from a two-entry receive buffer. Bit timing comes from an external tick. That tick pulses a fixed number of times per elementary time unit (ETU), so the block can place samples in the middle of a bit and can start an error break half an ETU into a bit period.

Each character has one low start bit, then eight data bits with the least significant bit first, then an even parity bit. At least two ETU of released line follow as guard time. A bad parity bit in a received character is handled by three independent host controls. The first raises a sticky status flag. The second pulls the line low as an error break so the card sends the character again. The third drops the character instead of storing it. A transmitted character is refused by the card when the card pulls the line low during the guard time. The block then sends the same character again, up to a fixed retry count. A test control inverts the transmitted parity on purpose.

Top module: `sc_t0_xcvr`

## Requirements
- R1: After reset the line is released (`io_drive_low`=0), both buffers are empty (`rx_valid`=0, `tx_full`=0), `tx_busy`=0 and all four status flags are 0.
- R2: A transmitted character starts with a low start bit, then sends data bits 0 to 7 in that order, then a parity bit equal to the XOR of the data. Each bit lasts SUB_TICKS ticks (one ETU). The line stays released for at least the next two ETU.
- R3: While `par_inject`=1, a character being loaded for sending gets the inverse of its correct even parity bit.
- R4: A character that starts while the transmitter is idle is sampled in the middle of each bit. A character with correct parity is appended to the receive buffer. `rx_rdata` shows the oldest entry while `rx_valid`=1, and `rx_pop` removes it.
- R5: The receive buffer holds two characters. A character that arrives while it is full is dropped and sets `st_rx_overrun`. The two stored characters come out in arrival order.
- R6: The transmit buffer holds two bytes and raises `tx_full` when both entries are in use. The bytes are sent in the order they were pushed.
- R7: With `par_chk_en`=0, a received character with odd parity is stored. It raises no flag and causes no break.
- R8: With checking on, a parity error sets `st_rx_parity` only when `err_report_en`=1. It pulls the line low from 10.5 ETU to 11.5 ETU after the detected start only when `break_en`=1. The two controls act independently.
- R9: With checking on, a character with a parity error is left out of the receive buffer when `del_en`=1 and is stored when `del_en`=0.
- R10: A low line sampled 11 ETU after a transmitted start bit sets `st_tx_nack`. With `retx_en`=1 the same byte is sent again, starting 13 ETU after the previous start. With `retx_en`=0 it is not sent again.
- R11: With `retx_en`=1, a byte is sent at most MAX_RETRY+1 times (default 4). If the last attempt is also refused, the byte is dropped, `st_tx_retry_fail` is set, and the transmitter goes idle.
- R12: A one-cycle pulse on `status_clr` clears all four status flags.
- R13: The receiver ignores the line while the transmitter is busy. A character the block sends itself never appears in the receive buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| etu_tick | input | 1 | Timing tick, SUB_TICKS pulses per ETU |
| io_in | input | 1 | Level of the shared I/O line as read back |
| io_drive_low | output | 1 | 1 pulls the shared line low, 0 releases it |
| tx_wdata | input | 8 | Byte to transmit |
| tx_push | input | 1 | Writes `tx_wdata` into the transmit buffer; ignored when full |
| tx_full | output | 1 | Transmit buffer holds two bytes |
| rx_rdata | output | 8 | Oldest received byte |
| rx_pop | input | 1 | Removes the oldest received byte |
| rx_valid | output | 1 | Receive buffer not empty |
| par_chk_en | input | 1 | Enables receive parity checking |
| err_report_en | input | 1 | Sets the parity status flag on a receive parity error |
| break_en | input | 1 | Sends an error break on a receive parity error |
| retx_en | input | 1 | Resends a character the card refuses |
| del_en | input | 1 | Drops a received character with a parity error |
| par_inject | input | 1 | Sends inverted parity (test mode) |
| status_clr | input | 1 | Clears the sticky status flags |
| tx_busy | output | 1 | Transmitter is sending or waiting out guard time |
| st_rx_parity | output | 1 | Sticky: reported receive parity error |
| st_rx_overrun | output | 1 | Sticky: a received character was dropped because the buffer was full |
| st_tx_nack | output | 1 | Sticky: the card signalled an error on a transmitted character |
| st_tx_retry_fail | output | 1 | Sticky: a character was refused on every allowed attempt |

## Verification
The line output changes on the clock edge after a tick, so each transmitted bit lasts 16 clocks with the bench's tick period of four clocks. The bench decodes frames at mid-bit, 8 + 16k clocks after it sees the falling start edge. A received character reaches the buffer 38 ticks after the tick that detects the start, which is within 156 clocks of the card's start edge. The break begins 168 to 172 clocks after that edge and ends within 188 clocks, so the bench samples the drive at +160, +176 and +200. The refusal sample lies 176 clocks after the transmitter's start edge and the resend lies 208 clocks after it. The bench's card pulls the line low over clocks 168 to 184 and looks for repeat frames over a 320-clock window. All samples are taken on falling clock edges.

// File: rtl/sc_pkg.sv
// Shared types and helpers for the T=0 character transceiver.
package sc_pkg;
    typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;

    // Even parity bit for one data byte.
    function automatic logic even_par(input logic [7:0] d);
        return ^d;
    endfunction
endpackage

// File: rtl/sc_fifo2.sv
// Small first-in first-out buffer.
// Assumes: a push while full and a pop while empty are both ignored.
module sc_fifo2 #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic do_push, do_pop;

    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    p_full_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
    p_push_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !empty);
endmodule

// File: rtl/sc_tx.sv
// Character transmitter for the shared open-drain line.
// Sends start, 8 data bits LSB first and parity, then guard time. It samples
// the line 11 ETU after the start to catch a card error signal, and resends
// up to MAX_RETRY times when enabled.
// Assumes: the tick comes SUB pulses per ETU, and SUB is even and at least 2.
module sc_tx #(
    parameter int SUB       = 4,
    parameter int MAX_RETRY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line_in,
    input  logic       rx_busy,
    input  logic       have_data,
    input  logic [7:0] din,
    input  logic       retx_en,
    input  logic       par_inject,
    input  logic       status_clr,
    output logic       take,
    output logic       drive_low,
    output logic       busy,
    output logic       st_nack,
    output logic       st_retry_fail
);
    import sc_pkg::*;

    localparam int CW       = $clog2(13*SUB + 1);
    localparam int RW       = $clog2(MAX_RETRY + 1) + 1;
    localparam int END_OK   = 12*SUB - 1;
    localparam int END_ERR  = 13*SUB - 1;
    localparam int GUARD_SM = 11*SUB;

    phase_e         state;
    logic [CW-1:0]  tcnt, nxt, bidx;
    logic [7:0]     sh, shv;
    logic           par, nack, drv_nxt, frame_end;
    logic [RW-1:0]  rc;

    assign busy = (state == PH_RUN);
    assign take = tick && (state == PH_IDLE) && have_data && !rx_busy && line_in;

    // Line level for the next tick position inside the frame.
    always_comb begin
        nxt       = tcnt + 1'b1;
        bidx      = nxt / CW'(SUB);
        shv       = sh >> (bidx - CW'(1));
        frame_end = (tcnt == CW'(END_ERR)) || ((tcnt == CW'(END_OK)) && !nack);
        if (bidx == '0)            drv_nxt = 1'b1;
        else if (bidx <= CW'(8))   drv_nxt = !shv[0];
        else if (bidx == CW'(9))   drv_nxt = !par;
        else                       drv_nxt = 1'b0;
    end

    // Frame sequencing, refusal detection and retry control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= PH_IDLE;
            tcnt          <= '0;
            sh            <= '0;
            par           <= 1'b0;
            nack          <= 1'b0;
            rc            <= '0;
            drive_low     <= 1'b0;
            st_nack       <= 1'b0;
            st_retry_fail <= 1'b0;
        end else begin
            if (status_clr) begin
                st_nack       <= 1'b0;
                st_retry_fail <= 1'b0;
            end
            if (tick) begin
                if (state == PH_IDLE) begin
                    if (take) begin
                        sh        <= din;
                        par       <= even_par(din) ^ par_inject;
                        tcnt      <= '0;
                        nack      <= 1'b0;
                        rc        <= '0;
                        drive_low <= 1'b1;
                        state     <= PH_RUN;
                    end
                end else if (frame_end) begin
                    if (nack && retx_en && (rc < RW'(MAX_RETRY))) begin
                        rc        <= rc + 1'b1;
                        tcnt      <= '0;
                        nack      <= 1'b0;
                        drive_low <= 1'b1;
                    end else begin
                        if (nack && retx_en) st_retry_fail <= 1'b1;
                        drive_low <= 1'b0;
                        state     <= PH_IDLE;
                    end
                end else begin
                    tcnt      <= nxt;
                    drive_low <= drv_nxt;
                    if (nxt == CW'(GUARD_SM) && !line_in) begin
                        nack    <= 1'b1;
                        st_nack <= 1'b1;
                    end
                end
            end
        end
    end

    p_retry_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rc <= RW'(MAX_RETRY));
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> drive_low);
    p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drive_low);
endmodule

// File: rtl/sc_rx.sv
// Character receiver for the shared open-drain line.
// Samples each bit at mid-ETU, checks even parity, can send an error break
// from 10.5 to 11.5 ETU and can drop a character that has a parity error.
// Assumes: SUB ticks per ETU, SUB even; ignores the line while tx_busy is high.
module sc_rx #(
    parameter int SUB = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       line_in,
    input  logic       tx_busy,
    input  logic       par_chk_en,
    input  logic       err_report_en,
    input  logic       break_en,
    input  logic       del_en,
    input  logic       status_clr,
    input  logic       fifo_full,
    output logic       push,
    output logic [7:0] dout,
    output logic       drive_low,
    output logic       busy,
    output logic       st_parity,
    output logic       st_overrun
);
    import sc_pkg::*;

    localparam int CW      = $clog2(11*SUB + SUB/2 + 1);
    localparam int SMP_PAR = 9*SUB + SUB/2;
    localparam int BRK_ON  = 10*SUB + SUB/2;
    localparam int DONE    = 11*SUB + SUB/2;

    phase_e        state;
    logic [CW-1:0] rcnt, nxt, bidx;
    logic [7:0]    sh;
    logic          prev_hi, perr, at_smp, at_par, par_bad, store;

    assign busy = (state == PH_RUN);
    assign dout = sh;

    // Sample-point decode and parity decision.
    always_comb begin
        nxt     = rcnt + 1'b1;
        bidx    = nxt / CW'(SUB);
        at_smp  = ((nxt % CW'(SUB)) == CW'(SUB/2)) && (nxt <= CW'(SMP_PAR));
        at_par  = tick && busy && (nxt == CW'(SMP_PAR));
        par_bad = par_chk_en && (line_in != even_par(sh));
        store   = at_par && !(par_bad && del_en);
        push    = store && !fifo_full;
    end

    // Start detection, bit shifting, break generation and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PH_IDLE;
            rcnt       <= '0;
            sh         <= '0;
            prev_hi    <= 1'b0;
            perr       <= 1'b0;
            drive_low  <= 1'b0;
            st_parity  <= 1'b0;
            st_overrun <= 1'b0;
        end else begin
            if (status_clr) begin
                st_parity  <= 1'b0;
                st_overrun <= 1'b0;
            end
            if (tick) begin
                prev_hi <= line_in;
                if (state == PH_IDLE) begin
                    if (prev_hi && !line_in && !tx_busy) begin
                        rcnt  <= '0;
                        perr  <= 1'b0;
                        state <= PH_RUN;
                    end
                end else begin
                    rcnt <= nxt;
                    if (at_smp) begin
                        if (bidx == '0) begin
                            if (line_in) state <= PH_IDLE;
                        end else if (bidx <= CW'(8)) begin
                            sh <= {line_in, sh[7:1]};
                        end else begin
                            perr <= par_bad;
                            if (par_bad && err_report_en) st_parity <= 1'b1;
                            if (store && fifo_full) st_overrun <= 1'b1;
                        end
                    end
                    if (nxt == CW'(BRK_ON) && perr && break_en) drive_low <= 1'b1;
                    if (nxt == CW'(DONE)) begin
                        drive_low <= 1'b0;
                        state     <= PH_IDLE;
                    end
                end
            end
        end
    end

    p_break_needs_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drive_low |-> (perr && break_en));
    p_break_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !drive_low);
endmodule

// File: rtl/sc_t0_xcvr.sv
// Top level of the T=0 character transceiver: two host buffers, transmitter
// and receiver sharing one open-drain line.
// Assumes: io_in is already synchronous to clk.
module sc_t0_xcvr #(
    parameter int SUB_TICKS = 4,
    parameter int MAX_RETRY = 3,
    parameter int BUF_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       etu_tick,
    input  logic       io_in,
    output logic       io_drive_low,
    input  logic [7:0] tx_wdata,
    input  logic       tx_push,
    output logic       tx_full,
    output logic [7:0] rx_rdata,
    input  logic       rx_pop,
    output logic       rx_valid,
    input  logic       par_chk_en,
    input  logic       err_report_en,
    input  logic       break_en,
    input  logic       retx_en,
    input  logic       del_en,
    input  logic       par_inject,
    input  logic       status_clr,
    output logic       tx_busy,
    output logic       st_rx_parity,
    output logic       st_rx_overrun,
    output logic       st_tx_nack,
    output logic       st_tx_retry_fail
);
    logic [7:0] txq_dout, rxq_din;
    logic       txq_empty, txq_take, rxq_full, rxq_empty, rxq_push;
    logic       tx_drv, rx_drv, rx_busy;

    assign io_drive_low = tx_drv | rx_drv;
    assign rx_valid     = !rxq_empty;

    sc_fifo2 #(.W(8), .DEPTH(BUF_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(tx_wdata),
        .pop(txq_take), .dout(txq_dout), .full(tx_full), .empty(txq_empty)
    );

    sc_fifo2 #(.W(8), .DEPTH(BUF_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rxq_push), .din(rxq_din),
        .pop(rx_pop), .dout(rx_rdata), .full(rxq_full), .empty(rxq_empty)
    );

    sc_tx #(.SUB(SUB_TICKS), .MAX_RETRY(MAX_RETRY)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(etu_tick), .line_in(io_in),
        .rx_busy(rx_busy), .have_data(!txq_empty), .din(txq_dout),
        .retx_en(retx_en), .par_inject(par_inject), .status_clr(status_clr),
        .take(txq_take), .drive_low(tx_drv), .busy(tx_busy),
        .st_nack(st_tx_nack), .st_retry_fail(st_tx_retry_fail)
    );

    sc_rx #(.SUB(SUB_TICKS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(etu_tick), .line_in(io_in),
        .tx_busy(tx_busy), .par_chk_en(par_chk_en),
        .err_report_en(err_report_en), .break_en(break_en), .del_en(del_en),
        .status_clr(status_clr), .fifo_full(rxq_full), .push(rxq_push),
        .dout(rxq_din), .drive_low(rx_drv), .busy(rx_busy),
        .st_parity(st_rx_parity), .st_overrun(st_rx_overrun)
    );

    p_half_duplex_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_busy && rx_busy));
endmodule

// File: tb/tb_sc_t0_xcvr.sv
`timescale 1ns/1ps
module tb_sc_t0_xcvr;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic etu_tick = 1'b0;
    logic tick_en = 1'b1;
    logic [1:0] tdiv = 2'd0;
    logic card_low = 1'b0;
    logic io_drive_low;
    logic [7:0] tx_wdata = 8'h00;
    logic tx_push = 1'b0, tx_full;
    logic [7:0] rx_rdata;
    logic rx_pop = 1'b0, rx_valid;
    logic par_chk_en = 1'b0, err_report_en = 1'b0, break_en = 1'b0;
    logic retx_en = 1'b0, del_en = 1'b0, par_inject = 1'b0, status_clr = 1'b0;
    logic tx_busy, st_rx_parity, st_rx_overrun, st_tx_nack, st_tx_retry_fail;
    wire  line_w = ~(io_drive_low | card_low);

    int errs = 0;
    int checks = 0;
    logic brk_pre, brk_mid, brk_post;

    sc_t0_xcvr dut (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .io_in(line_w),
        .io_drive_low(io_drive_low), .tx_wdata(tx_wdata), .tx_push(tx_push),
        .tx_full(tx_full), .rx_rdata(rx_rdata), .rx_pop(rx_pop),
        .rx_valid(rx_valid), .par_chk_en(par_chk_en),
        .err_report_en(err_report_en), .break_en(break_en), .retx_en(retx_en),
        .del_en(del_en), .par_inject(par_inject), .status_clr(status_clr),
        .tx_busy(tx_busy), .st_rx_parity(st_rx_parity),
        .st_rx_overrun(st_rx_overrun), .st_tx_nack(st_tx_nack),
        .st_tx_retry_fail(st_tx_retry_fail)
    );

    always #2.5 clk = ~clk;

    // One tick every four clocks: ETU = 16 clocks.
    always @(negedge clk) begin
        tdiv     <= tdiv + 2'd1;
        etu_tick <= tick_en && (tdiv == 2'd3);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_fall(input int tmo, output bit got);
        bit p;
        got = 1'b0;
        p = line_w;
        for (int i = 0; i < tmo; i++) begin
            @(negedge clk);
            if (p && !line_w) begin
                got = 1'b1;
                break;
            end
            p = line_w;
        end
    endtask

    // Decode a frame whose start edge was just seen; checks guard release.
    task automatic decode(input string req, output logic [7:0] d, output logic p, output bit st_ok, output bit grd_ok);
        repeat (8) @(negedge clk);
        st_ok = !line_w;
        for (int k = 1; k <= 9; k++) begin
            repeat (16) @(negedge clk);
            if (k <= 8) d[k-1] = line_w;
            else p = line_w;
        end
        grd_ok = 1'b1;
        for (int k = 10; k <= 11; k++) begin
            repeat (16) @(negedge clk);
            if (!line_w) grd_ok = 1'b0;
        end
        chk(st_ok, {req, " start bit low"}, 0, 0);
        chk(grd_ok, {req, " guard released"}, 0, 1);
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk);
        tx_wdata = b;
        tx_push  = 1'b1;
        @(negedge clk);
        tx_push  = 1'b0;
    endtask

    task automatic pop_rx;
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flags;
        @(negedge clk);
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    // Card sends one character; records the block's break drive around 11 ETU.
    task automatic card_send(input logic [7:0] b, input bit bad);
        @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            if (k == 0) card_low = 1'b1;
            else if (k <= 8) card_low = !b[k-1];
            else card_low = !((^b) ^ bad);
            repeat (16) @(negedge clk);
        end
        card_low = 1'b0;
        brk_pre  = io_drive_low;
        repeat (16) @(negedge clk);
        brk_mid  = io_drive_low;
        repeat (24) @(negedge clk);
        brk_post = io_drive_low;
        repeat (32) @(negedge clk);
    endtask

    // Card refuses the frame whose start was just seen.
    task automatic card_nack;
        repeat (168) @(negedge clk);
        card_low = 1'b1;
        repeat (16) @(negedge clk);
        card_low = 1'b0;
    endtask

    task automatic t_reset;
        chk(io_drive_low == 1'b0, "R1 line released", io_drive_low, 0);
        chk(!rx_valid && !tx_full && !tx_busy, "R1 buffers empty", {rx_valid, tx_full, tx_busy}, 0);
        chk({st_rx_parity, st_rx_overrun, st_tx_nack, st_tx_retry_fail} == 4'b0, "R1 flags clear",
            {st_rx_parity, st_rx_overrun, st_tx_nack, st_tx_retry_fail}, 0);
    endtask

    task automatic t_tx_frame(input logic [7:0] b, input bit inj, input string req);
        logic [7:0] d; logic p; bit got, s, g;
        par_inject = inj;
        push_tx(b);
        wait_fall(200, got);
        chk(got, {req, " frame seen"}, got, 1);
        decode(req, d, p, s, g);
        chk(d == b, {req, " data"}, d, b);
        chk(p == ((^b) ^ inj), {req, " parity"}, p, (^b) ^ inj);
        while (tx_busy) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(!rx_valid, "R13 own frame not received", rx_valid, 0);
        par_inject = 1'b0;
    endtask

    task automatic t_tx_two;
        logic [7:0] d; logic p; bit got, s, g;
        @(negedge clk);
        tick_en = 1'b0;
        repeat (8) @(negedge clk);
        push_tx(8'h3C);
        push_tx(8'hA1);
        chk(tx_full, "R6 full after two pushes", tx_full, 1);
        tick_en = 1'b1;
        wait_fall(200, got);
        decode("R6 first", d, p, s, g);
        chk(d == 8'h3C, "R6 first byte order", d, 8'h3C);
        wait_fall(200, got);
        chk(got, "R6 second frame seen", got, 1);
        decode("R6 second", d, p, s, g);
        chk(d == 8'hA1, "R6 second byte order", d, 8'hA1);
        while (tx_busy) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_rx_good;
        card_send(8'h5A, 1'b0);
        chk(rx_valid && rx_rdata == 8'h5A, "R4 received byte", rx_rdata, 8'h5A);
        chk(brk_mid == 1'b0, "R4 no break on good parity", brk_mid, 0);
        pop_rx();
        chk(!rx_valid, "R4 pop empties", rx_valid, 0);
    endtask

    task automatic t_rx_nocheck;
        par_chk_en = 1'b0; err_report_en = 1'b1; break_en = 1'b1; del_en = 1'b1;
        card_send(8'h81, 1'b1);
        chk(rx_valid && rx_rdata == 8'h81, "R7 unchecked byte stored", rx_rdata, 8'h81);
        chk(!st_rx_parity && brk_mid == 1'b0, "R7 no flag no break", {st_rx_parity, brk_mid}, 0);
        pop_rx();
    endtask

    task automatic t_rx_report_only;
        par_chk_en = 1'b1; err_report_en = 1'b1; break_en = 1'b0; del_en = 1'b0;
        card_send(8'h0F, 1'b1);
        chk(st_rx_parity, "R8 report flag set", st_rx_parity, 1);
        chk(brk_mid == 1'b0, "R8 no break when disabled", brk_mid, 0);
        chk(rx_valid && rx_rdata == 8'h0F, "R9 kept when deletion off", rx_rdata, 8'h0F);
        pop_rx();
        clear_flags();
        chk(!st_rx_parity, "R12 clear parity flag", st_rx_parity, 0);
    endtask

    task automatic t_rx_break_delete;
        par_chk_en = 1'b1; err_report_en = 1'b0; break_en = 1'b1; del_en = 1'b1;
        card_send(8'hE7, 1'b1);
        chk(brk_pre == 1'b0, "R8 break not before 10.5 ETU", brk_pre, 0);
        chk(brk_mid == 1'b1, "R8 break at 11 ETU", brk_mid, 1);
        chk(brk_post == 1'b0, "R8 break released", brk_post, 0);
        chk(!st_rx_parity, "R8 no report when disabled", st_rx_parity, 0);
        chk(!rx_valid, "R9 erroneous byte deleted", rx_valid, 1'b0);
        card_send(8'hE7, 1'b0);
        chk(rx_valid && rx_rdata == 8'hE7, "R9 good repeat stored", rx_rdata, 8'hE7);
        chk(brk_mid == 1'b0, "R8 no break on good repeat", brk_mid, 0);
        pop_rx();
        par_chk_en = 1'b0; break_en = 1'b0; del_en = 1'b0;
    endtask

    task automatic t_rx_overrun;
        card_send(8'h11, 1'b0);
        card_send(8'h22, 1'b0);
        card_send(8'h33, 1'b0);
        chk(st_rx_overrun, "R5 overrun flag", st_rx_overrun, 1);
        chk(rx_valid && rx_rdata == 8'h11, "R5 first kept", rx_rdata, 8'h11);
        pop_rx();
        chk(rx_valid && rx_rdata == 8'h22, "R5 second kept", rx_rdata, 8'h22);
        pop_rx();
        chk(!rx_valid, "R5 third dropped", rx_valid, 0);
        clear_flags();
        chk(!st_rx_overrun, "R12 clear overrun flag", st_rx_overrun, 0);
    endtask

    task automatic t_tx_resend;
        logic [7:0] d; logic p; bit got, s, g;
        retx_en = 1'b1;
        push_tx(8'hC3);
        wait_fall(200, got);
        card_nack();
        wait_fall(200, got);
        chk(got, "R10 resend occurs", got, 1);
        decode("R10 resend", d, p, s, g);
        chk(d == 8'hC3 && p == (^8'hC3), "R10 same byte resent", d, 8'hC3);
        while (tx_busy) @(negedge clk);
        chk(st_tx_nack && !st_tx_retry_fail, "R10 nack flag only", {st_tx_nack, st_tx_retry_fail}, 2);
        clear_flags();
    endtask

    task automatic t_tx_no_resend;
        bit got;
        retx_en = 1'b0;
        push_tx(8'h66);
        wait_fall(200, got);
        card_nack();
        wait_fall(320, got);
        chk(!got, "R10 no resend when disabled", got, 0);
        chk(st_tx_nack && !st_tx_retry_fail && !tx_busy, "R10 flags without resend",
            {st_tx_nack, st_tx_retry_fail, tx_busy}, 4);
        clear_flags();
        chk(!st_tx_nack, "R12 clear nack flag", st_tx_nack, 0);
    endtask

    task automatic t_tx_retry_limit;
        bit got;
        int frames;
        retx_en = 1'b1;
        frames = 0;
        push_tx(8'h9D);
        for (int i = 0; i < 6; i++) begin
            wait_fall(320, got);
            if (!got) break;
            frames++;
            card_nack();
        end
        chk(frames == 4, "R11 attempts bounded", frames, 4);
        chk(st_tx_retry_fail && !tx_busy, "R11 retry fail flag and idle", {st_tx_retry_fail, tx_busy}, 2);
        clear_flags();
        chk(!st_tx_retry_fail, "R12 clear retry flag", st_tx_retry_fail, 0);
        retx_en = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        repeat (20) @(negedge clk);
        t_tx_frame(8'hB4, 1'b0, "R2");
        t_tx_frame(8'h01, 1'b0, "R2 odd");
        t_tx_frame(8'hB4, 1'b1, "R3");
        t_tx_two();
        t_rx_good();
        t_rx_nocheck();
        t_rx_report_only();
        t_rx_break_delete();
        t_rx_overrun();
        t_tx_resend();
        t_tx_no_resend();
        t_tx_retry_limit();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule